// File: doc/BRIEF.md
# Burst Cache-Line Bus Reader

This controller sits between an instruction cache and a memory bus whose address and data paths are separate. When the cache misses, it is handed a word address. It then fetches the whole 16-byte aligned line that holds that word, over a 32-bit data bus, and passes each word on to the cache-fill port together with that word's position in the line. The first word is the one that was asked for. The rest follow in wrapping order, so the word the fetch unit is waiting on arrives first.

Every transfer starts with a basic two-clock cycle: one address clock, then one data clock. Memory can stretch the data clock with wait states by holding its ready input low. On the first transfer of a line, the controller asks memory for a burst. If memory accepts, the other three words arrive one per clock. If memory declines, the controller fetches the rest of the line as separate two-clock cycles. Data reads and uncacheable reads never burst: each one is a single two-clock transfer that returns exactly one word. A one-clock completion pulse ends every request, and the controller takes no new request until that pulse has been raised.

Top module: `burst_line_reader`

## Requirements
- R1: While reset is low, and in the first clock after it is released, `req_ready` is 1 and `fill_valid`, `fill_done`, `mem_strobe` and `mem_burst_req` are 0.
- R2: A request with `req_instr`=1 and `req_cacheable`=1 is a line fill. It delivers exactly four words, in the order start, start+1, ... modulo 4, where start is `req_waddr[1:0]`. Each word carries its line offset on `fill_word_idx`. Its bus address is `{req_waddr[29:2], fill_word_idx}`.
- R3: Every non-burst transfer has one address clock, in which `mem_strobe` is 1, followed by at least one data clock. A transfer with no wait states therefore takes two clocks, and a single-word request raises `fill_done` 4 clocks after the accepting edge.
- R4: Each data clock in which `mem_ready` is 0 captures no word and delays the rest of the request by exactly one clock.
- R5: `mem_burst_req` is 1 only during the address clock of the first transfer of a line fill. If `mem_burst_ack` is 1 when the first word is taken, the remaining three words are taken on consecutive ready clocks with no further strobe. With W first-word wait states, `fill_done` then comes 7+W clocks after acceptance.
- R6: If `mem_burst_ack` is 0 when the first word is taken, each remaining word uses its own two-clock transfer with a strobe, four strobes in all. `mem_burst_ack` has no effect on those later transfers, and `fill_done` comes 10+W clocks after acceptance.
- R7: `fill_done` is high for exactly one clock, in the clock right after the last word appears on the fill port. `req_ready` is 0 from the accepting edge through the `fill_done` clock, and a request held during that time is not taken.
- R8: Any request that is not a line fill makes one transfer of the requested word only. It never raises `mem_burst_req`, and it ignores `mem_burst_ack`.
- R9: `fill_data` equals the value on `mem_data` at the clock edge where that word's data clock saw `mem_ready` high. It appears one clock later with `fill_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Fetch request present |
| req_waddr | input | 30 | Requested 32-bit word address (byte address bits 31:2) |
| req_instr | input | 1 | Request is an instruction fetch |
| req_cacheable | input | 1 | Requested page may be cached |
| req_ready | output | 1 | Controller idle, request taken on this clock |
| mem_waddr | output | 30 | Word address of the current transfer |
| mem_strobe | output | 1 | Address clock of a transfer |
| mem_burst_req | output | 1 | Burst requested for this line |
| mem_ready | input | 1 | Memory has data on this data clock |
| mem_burst_ack | input | 1 | Memory accepts the burst (sampled with first word) |
| mem_data | input | 32 | Read data from memory |
| fill_valid | output | 1 | Word present on the fill port |
| fill_word_idx | output | 2 | Offset of the word within its line |
| fill_data | output | 32 | Word for the cache |
| fill_done | output | 1 | One-clock completion pulse |

## Verification
The properties assume that memory drives `mem_ready` and `mem_burst_ack` as clean levels on every clock. They also assume that memory keeps returning data for whatever `mem_waddr` shows, and never aborts a transfer part-way. The bench's memory model computes data from the presented address on every clock. It delays only the first data clock of a request, or a single chosen clock inside a burst. It holds the burst acceptance steady for the first word and forces it high afterwards, which exposes any reliance on late acceptance. A request is presented only once the controller shows it is idle, and is then held through the busy period to probe the accept gating.

// File: rtl/blr_pkg.sv
// Shared types for the burst cache-line reader.
// Assumes nothing beyond the default 32-bit address and data sizes.
package blr_pkg;

    // Bus sequencing states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // waiting for a request
        ST_ADDR  = 3'd1,   // address clock of a two-clock transfer
        ST_DATA  = 3'd2,   // data clock, may be stretched by wait states
        ST_BURST = 3'd3,   // streaming remaining line words
        ST_LAST  = 3'd4,   // last word is on the fill port
        ST_DONE  = 3'd5    // completion pulse
    } blr_state_e;

endpackage

// File: rtl/blr_addr_seq.sv
// Address sequencer: holds the line base and the starting word, and counts
// the words taken so far. The current word offset wraps inside the line.
// Assumes LINE_WORDS is a power of two, so the offset wraps by overflow.
module blr_addr_seq #(
    parameter int WADDR_W    = 30,
    parameter int LINE_WORDS = 4,
    localparam int IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [WADDR_W-1:0] load_waddr,
    input  logic               advance,
    output logic [WADDR_W-1:0] cur_waddr,
    output logic [IDX_W-1:0]   cur_idx,
    output logic               last_word
);

    logic [WADDR_W-IDX_W-1:0] line_base;
    logic [IDX_W-1:0]         start_idx;
    logic [IDX_W-1:0]         taken;

    // Latch the line base and start offset on accept; count taken words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_base <= '0;
            start_idx <= '0;
            taken     <= '0;
        end else if (load) begin
            line_base <= load_waddr[WADDR_W-1:IDX_W];
            start_idx <= load_waddr[IDX_W-1:0];
            taken     <= '0;
        end else if (advance) begin
            taken <= taken + 1'b1;
        end
    end

    // Wrapping word offset and the resulting bus address
    always_comb begin
        cur_idx   = start_idx + taken;
        cur_waddr = {line_base, cur_idx};
        last_word = (taken == IDX_W'(LINE_WORDS - 1));
    end

endmodule

// File: rtl/blr_bus_fsm.sv
// Bus state machine: runs two-clock transfers, asks for a burst on the
// first transfer of a line fill, streams when memory accepts it and falls
// back to separate transfers when it does not.
// Assumes memory samples mem_burst_req with the strobe and answers with
// mem_burst_ack together with the first ready.
module blr_bus_fsm
    import blr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_line,
    input  logic mem_ready,
    input  logic mem_burst_ack,
    input  logic last_word,
    output logic req_ready,
    output logic load,
    output logic capture,
    output logic mem_strobe,
    output logic mem_burst_req,
    output logic fill_done
);

    blr_state_e state, state_nx;
    logic       is_line;
    logic       first;
    logic       finish;

    // Decode handshake strobes from the current state
    always_comb begin
        req_ready     = (state == ST_IDLE);
        load          = req_ready && req_valid;
        capture       = mem_ready && ((state == ST_DATA) || (state == ST_BURST));
        mem_strobe    = (state == ST_ADDR);
        mem_burst_req = (state == ST_ADDR) && is_line && first;
        fill_done     = (state == ST_DONE);
        finish        = !is_line || last_word;
    end

    // Next-state selection
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (load) state_nx = ST_ADDR;
            ST_ADDR:  state_nx = ST_DATA;
            ST_DATA: begin
                if (mem_ready) begin
                    if (finish)                      state_nx = ST_LAST;
                    else if (first && mem_burst_ack) state_nx = ST_BURST;
                    else                             state_nx = ST_ADDR;
                end
            end
            ST_BURST: if (mem_ready && last_word) state_nx = ST_LAST;
            ST_LAST:  state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register plus per-request mode and first-transfer flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            is_line <= 1'b0;
            first   <= 1'b0;
        end else begin
            state <= state_nx;
            if (load) begin
                is_line <= req_line;
                first   <= 1'b1;
            end else if (capture) begin
                first <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/blr_fill_port.sv
// Fill port register: presents each captured word with its line offset
// for one clock. Assumes the cache takes a word whenever fill_valid is high.
module blr_fill_port #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [DATA_W-1:0] cap_data,
    output logic              fill_valid,
    output logic [IDX_W-1:0]  fill_word_idx,
    output logic [DATA_W-1:0] fill_data
);

    // Register the bus word on its capture clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_valid    <= 1'b0;
            fill_word_idx <= '0;
            fill_data     <= '0;
        end else begin
            fill_valid <= capture;
            if (capture) begin
                fill_word_idx <= cap_idx;
                fill_data     <= cap_data;
            end
        end
    end

endmodule

// File: rtl/burst_line_reader.sv
// Burst cache-line reader top: fetches the aligned line around a requested
// word, starting with that word, with a bursted or single-cycle fallback.
// Assumes a single outstanding request and a memory that never aborts.
module burst_line_reader #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    localparam int BYTE_W    = $clog2(DATA_W / 8),
    localparam int WADDR_W   = ADDR_W - BYTE_W,
    localparam int IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [WADDR_W-1:0] req_waddr,
    input  logic               req_instr,
    input  logic               req_cacheable,
    output logic               req_ready,
    output logic [WADDR_W-1:0] mem_waddr,
    output logic               mem_strobe,
    output logic               mem_burst_req,
    input  logic               mem_ready,
    input  logic               mem_burst_ack,
    input  logic [DATA_W-1:0]  mem_data,
    output logic               fill_valid,
    output logic [IDX_W-1:0]   fill_word_idx,
    output logic [DATA_W-1:0]  fill_data,
    output logic               fill_done
);

    logic             load;
    logic             capture;
    logic             last_word;
    logic [IDX_W-1:0] cur_idx;
    logic             req_line;

    // Only cacheable instruction fetches fill whole lines
    always_comb req_line = req_instr && req_cacheable;

    blr_addr_seq #(
        .WADDR_W    (WADDR_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_waddr (req_waddr),
        .advance    (capture),
        .cur_waddr  (mem_waddr),
        .cur_idx    (cur_idx),
        .last_word  (last_word)
    );

    blr_bus_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_line      (req_line),
        .mem_ready     (mem_ready),
        .mem_burst_ack (mem_burst_ack),
        .last_word     (last_word),
        .req_ready     (req_ready),
        .load          (load),
        .capture       (capture),
        .mem_strobe    (mem_strobe),
        .mem_burst_req (mem_burst_req),
        .fill_done     (fill_done)
    );

    blr_fill_port #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_fill (
        .clk           (clk),
        .rst_n         (rst_n),
        .capture       (capture),
        .cap_idx       (cur_idx),
        .cap_data      (mem_data),
        .fill_valid    (fill_valid),
        .fill_word_idx (fill_word_idx),
        .fill_data     (fill_data)
    );

endmodule

// File: rtl/blr_checker.sv
// Protocol checker for burst_line_reader, attached by bind.
// Assumes the memory inputs are clean levels on every clock.
module blr_checker #(
    parameter int LINE_WORDS = 4,
    localparam int CNT_W     = $clog2(LINE_WORDS) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic mem_strobe,
    input logic mem_burst_req,
    input logic fill_valid,
    input logic fill_done
);

    logic [CNT_W-1:0] words_seen;

    // Count fill words since the last completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n)          words_seen <= '0;
        else if (fill_done)  words_seen <= '0;
        else if (fill_valid) words_seen <= words_seen + 1'b1;
    end

    AST_BURST_REQ_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_burst_req |-> mem_strobe);                                      // R5
    AST_STROBE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_strobe |=> !mem_strobe);                                        // R3
    AST_ACCEPT_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_strobe);                           // R3
    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !fill_done);                                          // R7
    AST_DONE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> $past(fill_valid));                                   // R7
    AST_BUSY_DURING_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid || fill_done) |-> !req_ready);                          // R7
    AST_LINE_WORD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (words_seen < CNT_W'(LINE_WORDS)));                  // R2

endmodule

bind burst_line_reader blr_checker #(.LINE_WORDS(LINE_WORDS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_strobe    (mem_strobe),
    .mem_burst_req (mem_burst_req),
    .fill_valid    (fill_valid),
    .fill_done     (fill_done)
);

// File: tb/sim_burst_line_reader.sv
// Self-checking bench for burst_line_reader: a vector table walked by one
// loop, then directed reset, stall and back-to-back cases.
module sim_burst_line_reader;

    localparam logic [31:0] MAGIC = 32'h5A3C_0F96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [29:0] req_waddr = '0;
    logic        req_instr = 1'b0;
    logic        req_cacheable = 1'b0;
    logic        req_ready;
    logic [29:0] mem_waddr;
    logic        mem_strobe;
    logic        mem_burst_req;
    logic        mem_ready = 1'b1;
    logic        mem_burst_ack = 1'b0;
    logic [31:0] mem_data;
    logic        fill_valid;
    logic [1:0]  fill_word_idx;
    logic [31:0] fill_data;
    logic        fill_done;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    // Memory model: data is a fixed function of the presented word address
    assign mem_data = {mem_waddr, 2'b00} ^ MAGIC;

    burst_line_reader u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_waddr(req_waddr),
        .req_instr(req_instr), .req_cacheable(req_cacheable), .req_ready(req_ready),
        .mem_waddr(mem_waddr), .mem_strobe(mem_strobe), .mem_burst_req(mem_burst_req),
        .mem_ready(mem_ready), .mem_burst_ack(mem_burst_ack), .mem_data(mem_data),
        .fill_valid(fill_valid), .fill_word_idx(fill_word_idx), .fill_data(fill_data),
        .fill_done(fill_done)
    );

    // {byte address, instr, cacheable, burst accept, first-word waits}
    localparam int NV = 8;
    localparam logic [37:0] VEC [NV] = '{
        {32'h0000_1000, 1'b1, 1'b1, 1'b1, 3'd0},
        {32'h0000_2008, 1'b1, 1'b1, 1'b1, 3'd0},
        {32'h1234_567C, 1'b1, 1'b1, 1'b1, 3'd2},
        {32'h0000_3004, 1'b1, 1'b1, 1'b0, 3'd0},
        {32'hFFFF_FFF4, 1'b1, 1'b1, 1'b0, 3'd1},
        {32'h0000_4008, 1'b0, 1'b1, 1'b1, 3'd0},
        {32'h0000_500C, 1'b1, 1'b0, 1'b1, 3'd3},
        {32'h8000_0006, 1'b0, 1'b0, 1'b0, 3'd0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue one request, play memory, then check everything it produced
    task automatic run_req(input logic [31:0] a, input logic ins, input logic cch,
                           input logic ack, input int w, input int stall);
        bit          line = ins & cch;
        int          nf = 0, ns = 0, wc = 0, done_c = 0, last_fill_c = 0;
        bit          bseen = 0;
        logic [1:0]  fi [8];
        logic [31:0] fd [8];
        int          exp_n, exp_done, exp_ns;
        @(negedge clk);
        chk("R7", "ready before request", {31'd0, req_ready}, 32'd1);
        req_waddr = a[31:2]; req_instr = ins; req_cacheable = cch; req_valid = 1'b1;
        for (int cyc = 1; cyc <= 60 && done_c == 0; cyc++) begin
            @(negedge clk);
            if (cyc == 1) begin
                chk("R7", "ready low after accept", {31'd0, req_ready}, 32'd0);
                req_waddr = ~a[31:2];   // held busy request must be ignored
            end
            if (mem_strobe) begin
                ns++;
                if (ns == 1) wc = w + 1;
            end else if (wc > 0) begin
                wc--;
            end
            mem_ready     = (wc == 0) && (cyc != stall);
            mem_burst_ack = (ns <= 1) ? ack : 1'b1;
            if (mem_burst_req) bseen = 1;
            if (fill_valid) begin
                if (nf < 8) begin fi[nf] = fill_word_idx; fd[nf] = fill_data; end
                nf++;
                last_fill_c = cyc;
            end
            if (fill_done) begin done_c = cyc; req_valid = 1'b0; end
        end
        @(negedge clk);
        mem_ready = 1'b1;
        chk("R7", "ready after done", {31'd0, req_ready}, 32'd1);
        chk("R7", "no strobe from held request", {31'd0, mem_strobe}, 32'd0);
        chk("R7", "done one clock", {31'd0, fill_done}, 32'd0);
        exp_n    = line ? 4 : 1;
        exp_ns   = line ? (ack ? 1 : 4) : 1;
        exp_done = (line ? (ack ? 7 : 10) : 4) + w + ((stall > 0) ? 1 : 0);
        chk(line ? "R2" : "R8", "word count", nf, exp_n);
        for (int k = 0; k < exp_n && k < nf; k++) begin
            logic [1:0] ei = a[3:2] + 2'(k);
            chk("R2", "word offset", {30'd0, fi[k]}, {30'd0, ei});
            chk("R9", "word data", fd[k], {a[31:4], ei, 2'b00} ^ MAGIC);
        end
        if (line && ack)  chk("R5", "done cycle burst", done_c, exp_done);
        else if (line)    chk("R6", "done cycle fallback", done_c, exp_done);
        else              chk("R3", "done cycle single", done_c, exp_done);
        if (w > 0)        chk("R4", "wait states add clocks", done_c, exp_done);
        chk("R7", "done follows last word", done_c, last_fill_c + 1);
        chk(line ? "R6" : "R8", "strobe count", ns, exp_ns);
        chk(line ? "R5" : "R8", "burst request seen", {31'd0, bseen}, {31'd0, line});
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #2_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: outputs idle during and right after reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "ready in reset", {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1", "fill_valid", {31'd0, fill_valid}, 32'd0);
        chk("R1", "fill_done", {31'd0, fill_done}, 32'd0);
        chk("R1", "strobe", {31'd0, mem_strobe}, 32'd0);
        chk("R1", "burst request", {31'd0, mem_burst_req}, 32'd0);

        // Table walk over modes, start offsets and wait states
        for (int v = 0; v < NV; v++) begin
            run_req(VEC[v][37:6], VEC[v][5], VEC[v][4], VEC[v][3], int'(VEC[v][2:0]), 0);
        end

        // R4: a not-ready clock inside the burst adds one clock
        run_req(32'h0000_6004, 1'b1, 1'b1, 1'b1, 0, 4);
        // R2: back-to-back line at the top offset
        run_req(32'h0000_700C, 1'b1, 1'b1, 1'b1, 0, 0);

        // R1: reset in the middle of a burst returns to idle
        @(negedge clk);
        req_waddr = 30'h100; req_instr = 1'b1; req_cacheable = 1'b1;
        mem_burst_ack = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "mid-burst reset fill_valid", {31'd0, fill_valid}, 32'd0);
        chk("R1", "mid-burst reset ready", {31'd0, req_ready}, 32'd1);
        chk("R1", "mid-burst reset strobe", {31'd0, mem_strobe}, 32'd0);
        rst_n = 1'b1;
        run_req(32'h0000_8008, 1'b0, 1'b1, 1'b1, 0, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule